// File: doc/BRIEF.md
# Injection-Side Flit Packetizer

This block sits between the network users of one tile and the local port of that tile's router, in the injection direction. A user hands over one request at a time. A request holds a destination tile coordinate, a one-hot intra-tile target, a two-bit message class and up to `MAX_WORDS` payload words. The block stores the request, then sends one flit per payload word to the router. Each flit is marked with its position in the packet and carries the virtual channel that the message class selects.

Each flit also carries the output port that the local router must use. The block works this port out with X-then-Y dimension-order routing, comparing the destination against the tile's own coordinate (`LOCAL_X`, `LOCAL_Y`). The router raises a per-channel stop signal when a channel buffer is full. While the stop signal of the packet's channel is high, the block offers no flit.

Only one packet is in flight at a time. Flits of different packets therefore never interleave, on any channel.

Top module: `flit_packetizer`

## Requirements
- R1: A flit is `{type[1:0], vc[1:0], port[2:0], dst_y, dst_x, target[4:0], word}`, MSB first. The target field carries the request's one-hot code unchanged (5'b00001 directory controller, 5'b00010 cache controller). Flit k carries payload word k, where word k is `req_payload[k*WORD_W +: WORD_W]`.
- R2: Flit types are encoded HEADER=0, BODY=1, TAIL=2, HT=3. A one-flit packet is HT. A longer packet is HEADER, then BODY flits, then TAIL, with flits leaving in word order.
- R3: The vc field equals the message class: 0 request, 1 response, 2 forward, 3 service. Every flit of a packet carries the same vc.
- R4: The port field is encoded LOCAL=0, EAST=1, NORTH=2, WEST=3, SOUTH=4. X is resolved first: dst_x > LOCAL_X gives EAST and dst_x < LOCAL_X gives WEST. When the x values are equal, dst_y < LOCAL_Y gives NORTH, dst_y > LOCAL_Y gives SOUTH, and equal y gives LOCAL.
- R5: `flit_valid` is never high while `flit_onoff[vc]` is high for the vc that the pending flit carries. Sending resumes once that bit falls.
- R6: `req_ready` falls in the cycle after a request is accepted. It stays low until the cycle after the last flit is taken (`flit_valid && flit_ready`). A request offered while `req_ready` is low is not taken and does not alter the flits in progress.
- R7: A request of length N produces N flits. A length of 0 is treated as 1, and a length above `MAX_WORDS` is treated as `MAX_WORDS`.
- R8: After reset, `flit_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | User request offered |
| req_ready | output | 1 | Block can take a request |
| req_dst_x | input | X_W | Destination tile column |
| req_dst_y | input | Y_W | Destination tile row |
| req_target | input | TGT_W | One-hot intra-tile target |
| req_class | input | 2 | Message class |
| req_len | input | LEN_W | Number of payload words |
| req_payload | input | MAX_WORDS*WORD_W | Payload words, word 0 at the LSBs |
| flit_valid | output | 1 | Flit offered to the router |
| flit_ready | input | 1 | Router takes the flit |
| flit_onoff | input | 4 | Per-channel stop from the router |
| flit_data | output | FLIT_W | Flit contents |

## Verification
A wrong word index or a wrong length register shows in the very next flit taken. It appears as a wrong payload word or a wrong type field, or as a packet with too many or too few flits, and the user-side ready then returns too early or too late. A busy flag that fails to clear hangs the user side, and a flag that clears early lets a second request in while flits are still in progress. A stale routing or channel register shows on the first flit of the next packet. Since a stop bit suppresses output at once, a wrong channel select in the stall path shows as a flit offered under a raised stop bit in that same cycle.

// File: rtl/flit_packetizer.sv
module flit_packetizer #(
  parameter int WORD_W    = 32,
  parameter int MAX_WORDS = 4,
  parameter int X_W       = 2,
  parameter int Y_W       = 2,
  parameter int TGT_W     = 5,
  parameter int LOCAL_X   = 1,
  parameter int LOCAL_Y   = 1,
  localparam int LEN_W    = $clog2(MAX_WORDS + 1),
  localparam int FLIT_W   = 7 + Y_W + X_W + TGT_W + WORD_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [X_W-1:0]              req_dst_x,
  input  logic [Y_W-1:0]              req_dst_y,
  input  logic [TGT_W-1:0]            req_target,
  input  logic [1:0]                  req_class,
  input  logic [LEN_W-1:0]            req_len,
  input  logic [MAX_WORDS*WORD_W-1:0] req_payload,
  output logic                        flit_valid,
  input  logic                        flit_ready,
  input  logic [3:0]                  flit_onoff,
  output logic [FLIT_W-1:0]           flit_data
);
  localparam int IDX_W = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;
  localparam logic [LEN_W-1:0] MAXL = LEN_W'(MAX_WORDS);
  localparam int TYPE_LSB = FLIT_W - 2;
  localparam int VC_LSB   = FLIT_W - 4;

  localparam logic [1:0] T_HEAD = 2'd0, T_BODY = 2'd1, T_TAIL = 2'd2, T_HT = 2'd3;
  localparam logic [2:0] P_LOCAL = 3'd0, P_EAST = 3'd1, P_NORTH = 3'd2,
                         P_WEST = 3'd3, P_SOUTH = 3'd4;

  logic                             busy;
  logic [1:0]                       vc_q;
  logic [2:0]                       port_q;
  logic [Y_W-1:0]                   y_q;
  logic [X_W-1:0]                   x_q;
  logic [TGT_W-1:0]                 tgt_q;
  logic [IDX_W-1:0]                 idx_q, last_q;
  logic [MAX_WORDS-1:0][WORD_W-1:0] pay_q;

  logic [LEN_W-1:0] eff_len;
  logic [2:0]       route;
  logic [1:0]       ftype;
  logic             accept, fire, at_last;

  assign eff_len = (req_len == '0) ? LEN_W'(1) : (req_len > MAXL) ? MAXL : req_len;

  always_comb begin
    if (req_dst_x > X_W'(LOCAL_X))      route = P_EAST;
    else if (req_dst_x < X_W'(LOCAL_X)) route = P_WEST;
    else if (req_dst_y < Y_W'(LOCAL_Y)) route = P_NORTH;
    else if (req_dst_y > Y_W'(LOCAL_Y)) route = P_SOUTH;
    else                                route = P_LOCAL;
  end

  assign req_ready  = !busy;
  assign accept     = req_valid && req_ready;
  assign flit_valid = busy && !flit_onoff[vc_q];
  assign fire       = flit_valid && flit_ready;
  assign at_last    = idx_q == last_q;
  assign ftype      = (last_q == '0) ? T_HT : (idx_q == '0) ? T_HEAD : at_last ? T_TAIL : T_BODY;
  assign flit_data  = {ftype, vc_q, port_q, y_q, x_q, tgt_q, pay_q[idx_q]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
      vc_q   <= '0;
      port_q <= '0;
      y_q    <= '0;
      x_q    <= '0;
      tgt_q  <= '0;
      pay_q  <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      idx_q  <= '0;
      last_q <= IDX_W'(eff_len - LEN_W'(1));
      vc_q   <= req_class;
      port_q <= route;
      y_q    <= req_dst_y;
      x_q    <= req_dst_x;
      tgt_q  <= req_target;
      pay_q  <= req_payload;
    end else if (fire) begin
      if (at_last) busy <= 1'b0;
      else         idx_q <= idx_q + IDX_W'(1);
    end
  end

  p_no_send_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flit_valid |-> !flit_onoff[flit_data[VC_LSB +: 2]]);

  p_ready_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  p_ready_returns_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (flit_data[TYPE_LSB +: 2] == T_TAIL || flit_data[TYPE_LSB +: 2] == T_HT)) |=> req_ready);

  p_vc_from_class_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> flit_data[VC_LSB +: 2] == $past(req_class));

  p_mid_packet_type_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (flit_data[TYPE_LSB +: 2] == T_HEAD || flit_data[TYPE_LSB +: 2] == T_BODY))
      |=> (flit_data[TYPE_LSB +: 2] == T_BODY || flit_data[TYPE_LSB +: 2] == T_TAIL));

  p_hold_when_stalled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (flit_valid && !flit_ready) |=> (!flit_valid || $stable(flit_data)));
endmodule

// File: tb/tb_flit_packetizer.sv
module tb_flit_packetizer;
  localparam int WORD_W = 32, MAX_WORDS = 4, X_W = 2, Y_W = 2, TGT_W = 5;
  localparam int LX = 1, LY = 1;
  localparam int LEN_W  = $clog2(MAX_WORDS + 1);
  localparam int FLIT_W = 7 + Y_W + X_W + TGT_W + WORD_W;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [X_W-1:0] req_dst_x = 0;
  logic [Y_W-1:0] req_dst_y = 0;
  logic [TGT_W-1:0] req_target = 0;
  logic [1:0] req_class = 0;
  logic [LEN_W-1:0] req_len = 0;
  logic [MAX_WORDS*WORD_W-1:0] req_payload = 0;
  logic flit_valid, flit_ready = 1;
  logic [3:0] flit_onoff = 0;
  logic [FLIT_W-1:0] flit_data;

  int checks = 0, fails = 0, popped = 0, mode = 0;
  logic [FLIT_W-1:0] exp_q[$];

  always #10 clk = ~clk;

  flit_packetizer #(.WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS), .X_W(X_W), .Y_W(Y_W),
                    .TGT_W(TGT_W), .LOCAL_X(LX), .LOCAL_Y(LY)) dut (.*);

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] xy_port(input int dx, input int dy);
    if (dx > LX) return 3'd1;
    if (dx < LX) return 3'd3;
    if (dy < LY) return 3'd2;
    if (dy > LY) return 3'd4;
    return 3'd0;
  endfunction

  initial forever begin
    @(negedge clk);
    if (mode == 0) begin
      flit_ready = 1;
      flit_onoff = 0;
    end else begin
      flit_ready = ($urandom % 4) != 0;
      for (int b = 0; b < 4; b++) flit_onoff[b] = ($urandom % 3) == 0;
    end
  end

  always @(negedge clk) begin
    #8;
    if (rst_n) begin
      if (flit_valid)
        check(!flit_onoff[flit_data[FLIT_W-4 +: 2]], "R5 valid under stop", 64'(flit_onoff), 64'(flit_data[FLIT_W-4 +: 2]));
      if (exp_q.size() != 0)
        check(!req_ready, "R6 ready low while busy", 64'(req_ready), 64'd0);
      if (flit_valid && flit_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected flit", 64'(flit_data), 64'd0);
        end else begin
          logic [FLIT_W-1:0] e;
          e = exp_q.pop_front();
          popped++;
          check(flit_data[FLIT_W-1 -: 2] == e[FLIT_W-1 -: 2], "R2 type", 64'(flit_data[FLIT_W-1 -: 2]), 64'(e[FLIT_W-1 -: 2]));
          check(flit_data[FLIT_W-3 -: 2] == e[FLIT_W-3 -: 2], "R3 vc", 64'(flit_data[FLIT_W-3 -: 2]), 64'(e[FLIT_W-3 -: 2]));
          check(flit_data[FLIT_W-5 -: 3] == e[FLIT_W-5 -: 3], "R4 port", 64'(flit_data[FLIT_W-5 -: 3]), 64'(e[FLIT_W-5 -: 3]));
          check(flit_data[FLIT_W-8:0] == e[FLIT_W-8:0], "R1 fields", 64'(flit_data[FLIT_W-8:0]), 64'(e[FLIT_W-8:0]));
        end
      end
    end
  end

  task automatic send_req(input int dx, input int dy, input logic [4:0] tgt, input int cls, input int len, input int tagv);
    int n;
    logic [1:0] ty;
    n = (len == 0) ? 1 : (len > MAX_WORDS) ? MAX_WORDS : len;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_dst_x = X_W'(dx);
    req_dst_y = Y_W'(dy);
    req_target = tgt;
    req_class = 2'(cls);
    req_len = LEN_W'(len);
    for (int k = 0; k < MAX_WORDS; k++) req_payload[k*WORD_W +: WORD_W] = {8'(tagv), 16'hA5C3, 8'(k)};
    req_valid = 1;
    @(posedge clk);
    #1;
    popped = 0;
    for (int k = 0; k < n; k++) begin
      ty = (n == 1) ? 2'd3 : (k == 0) ? 2'd0 : (k == n - 1) ? 2'd2 : 2'd1;
      exp_q.push_back({ty, 2'(cls), xy_port(dx, dy), Y_W'(dy), X_W'(dx), tgt, req_payload[k*WORD_W +: WORD_W]});
    end
    @(negedge clk);
    req_dst_x = ~req_dst_x;
    req_class = ~req_class;
    req_target = 5'b10000;
    req_payload = ~req_payload;
    req_len = 3'd2;
    @(negedge clk);
    req_valid = 0;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    #8;
    check(req_ready, "R6 ready back after last flit", 64'(req_ready), 64'd1);
    check(popped == n, "R7 flit count", 64'(popped), 64'(n));
  endtask

  initial begin
    #(20 * 150000);
    check(1'b0, "watchdog expired", 64'd0, 64'd1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #8;
    check(!flit_valid, "R8 flit_valid in reset", 64'(flit_valid), 64'd0);
    rst_n = 1;
    @(negedge clk);
    #8;
    check(!flit_valid, "R8 flit_valid after reset", 64'(flit_valid), 64'd0);
    check(req_ready, "R8 req_ready after reset", 64'(req_ready), 64'd1);

    send_req(1, 1, 5'b00001, 0, 1, 1);
    send_req(3, 1, 5'b00010, 1, 2, 2);
    send_req(0, 2, 5'b00001, 2, 3, 3);
    send_req(1, 0, 5'b00010, 3, 4, 4);
    send_req(1, 3, 5'b00001, 0, 0, 5);
    send_req(2, 3, 5'b00010, 1, 7, 6);
    mode = 1;
    for (int i = 0; i < 40; i++)
      send_req(i % 4, (i / 4) % 4, (i % 2) ? 5'b00010 : 5'b00001, i % 4, i % 6, 16 + i);
    mode = 0;
    send_req(0, 0, 5'b00001, 2, 4, 99);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule